// File: doc/BRIEF.md
# Floating-Point Issue Arbiter with Divide Tracking

This block decides, every cycle, which of up to two floating-point instructions may enter execution, and on which pipe. There are two asymmetric pipes: an adder pipe (A) and a multiplier pipe (M). A divider that is not pipelined sits behind pipe A. Each issue slot carries a valid bit, a 3-bit class code and a precision bit that only divides use. Slot 0 always holds the older instruction.

For each slot the block returns a grant and the pipe it was given. It holds a busy flag for the divider. It raises one pulse per pipe, and one for the divider, in the cycle the result of a granted operation becomes ready. It does no arithmetic and does not track operand dependencies. The surrounding issue logic holds any slot that was not granted and offers it again.

Top module: `fpa_issue`

## Requirements
- R1: After reset, all of these are low until a new grant happens: the result pulses `a_res_vld`, `m_res_vld` and `div_res_vld`, and `div_busy`.
- R2: Class 0 (add) and class 1 (conditional move) are granted on pipe A, where `pipe` = 0. `a_res_vld` pulses for one cycle, 4 cycles after the issue cycle.
- R3: Class 2 (branch) is granted on pipe A. `a_res_vld` pulses 1 cycle after the issue cycle.
- R4: Class 3 (multiply) is granted on pipe M, where `pipe` = 1. `m_res_vld` pulses 4 cycles after the issue cycle.
- R5: Class 4 (copy-sign) may use either pipe. By default it goes to pipe A. It goes to pipe M when the other slot needs pipe A, either as a fixed-pipe class or by holding A already. Its result pulses 4 cycles later on the pipe it was given.
- R6: When both slots need the same fixed pipe, slot 0 is granted and slot 1 is not. Two grants in one cycle never share a pipe.
- R7: Slot 1 is never granted while slot 0 is valid and not granted.
- R8: A single-precision divide (class 5, `dbl` = 0) takes pipe A in its issue cycle. `div_busy` is high for the next 14 cycles. `div_res_vld` pulses 15 cycles after the issue cycle.
- R9: A double-precision divide (class 5, `dbl` = 1) keeps `div_busy` high for 21 cycles after issue. `div_res_vld` pulses 22 cycles after the issue cycle.
- R10: A divide is not granted while `div_busy` is high. A new divide can be granted in the cycle when the previous divide's result pulses.
- R11: Codes 6 and 7 are never granted and produce no result pulse. A slot that is not granted reports `pipe` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s0_vld | input | 1 | Older slot holds an instruction |
| s0_cls | input | 3 | Older slot class code |
| s0_dbl | input | 1 | Older slot divide is double precision |
| s1_vld | input | 1 | Younger slot holds an instruction |
| s1_cls | input | 3 | Younger slot class code |
| s1_dbl | input | 1 | Younger slot divide is double precision |
| s0_gnt | output | 1 | Older slot issues this cycle |
| s0_pipe | output | 1 | Pipe given to the older slot (0 = A, 1 = M) |
| s1_gnt | output | 1 | Younger slot issues this cycle |
| s1_pipe | output | 1 | Pipe given to the younger slot |
| div_busy | output | 1 | Divider still occupied by an earlier divide |
| a_res_vld | output | 1 | Result pulse for pipe A |
| m_res_vld | output | 1 | Result pulse for pipe M |
| div_res_vld | output | 1 | Result pulse for the divider |

## Verification
The assertions assume the issue stage never offers two instructions whose results would collide on one pipe in the same cycle. If they did, the two pulses would merge into one and the latency checks could not tell them apart. The assertions also assume slot 0 is older than slot 1 in program order. The stimulus follows both rules. Grant vectors are applied while the divider is idle. Every latency probe issues a single instruction and then waits until its pulse has passed before the next probe starts. Divide probes start only after `div_busy` has dropped.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  localparam int CLS_W = 3;

  localparam logic [CLS_W-1:0] C_ADD  = 3'd0;
  localparam logic [CLS_W-1:0] C_CMOV = 3'd1;
  localparam logic [CLS_W-1:0] C_BR   = 3'd2;
  localparam logic [CLS_W-1:0] C_MUL  = 3'd3;
  localparam logic [CLS_W-1:0] C_CPYS = 3'd4;
  localparam logic [CLS_W-1:0] C_DIV  = 3'd5;

  localparam logic P_A = 1'b0;
  localparam logic P_M = 1'b1;

  function automatic logic needs_a(input logic [CLS_W-1:0] c);
    return (c == C_ADD) || (c == C_CMOV) || (c == C_BR) || (c == C_DIV);
  endfunction

  function automatic logic needs_m(input logic [CLS_W-1:0] c);
    return c == C_MUL;
  endfunction

  function automatic logic known(input logic [CLS_W-1:0] c);
    return c <= C_DIV;
  endfunction
endpackage

// File: rtl/fpa_arb.sv
module fpa_arb
  import fpa_pkg::*;
(
  input  logic             s0_vld,
  input  logic [CLS_W-1:0] s0_cls,
  input  logic             s1_vld,
  input  logic [CLS_W-1:0] s1_cls,
  input  logic             div_busy,
  output logic             gnt0,
  output logic             pipe0,
  output logic             gnt1,
  output logic             pipe1
);
  logic ok0, ok1, s1_fixed_a;

  always_comb begin
    ok0 = s0_vld && known(s0_cls) && !((s0_cls == C_DIV) && div_busy);
    ok1 = s1_vld && known(s1_cls) && !((s1_cls == C_DIV) && div_busy)
          && (!s0_vld || ok0);
    s1_fixed_a = s1_vld && needs_a(s1_cls);

    gnt0  = ok0;
    pipe0 = P_A;
    if (ok0) begin
      if (needs_m(s0_cls))
        pipe0 = P_M;
      else if ((s0_cls == C_CPYS) && s1_fixed_a)
        pipe0 = P_M;
    end

    gnt1  = 1'b0;
    pipe1 = P_A;
    if (ok1) begin
      if (needs_a(s1_cls)) begin
        gnt1  = !(ok0 && (pipe0 == P_A));
        pipe1 = P_A;
      end else if (needs_m(s1_cls)) begin
        gnt1  = !(ok0 && (pipe0 == P_M));
        pipe1 = gnt1 ? P_M : P_A;
      end else begin
        gnt1  = 1'b1;
        pipe1 = (ok0 && (pipe0 == P_A)) ? P_M : P_A;
      end
    end
  end
endmodule

// File: rtl/fpa_lat_pipe.sv
module fpa_lat_pipe #(
  parameter int LONG_LAT  = 4,
  parameter int SHORT_LAT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inj_long,
  input  logic inj_short,
  output logic res_vld
);
  localparam int D = LONG_LAT;

  logic [D-1:0] sr_q, sr_d;
  logic         en;

  always_comb begin
    sr_d = sr_q >> 1;
    if (inj_long)  sr_d[LONG_LAT-1]  = 1'b1;
    if (inj_short) sr_d[SHORT_LAT-1] = 1'b1;
    en = inj_long || inj_short || (|sr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sr_q <= '0;
    else if (en) sr_q <= sr_d;
  end

  assign res_vld = sr_q[0];

  // R6: one instruction per pipe per cycle, so two injects never meet
  p_one_inject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(inj_long && inj_short));
endmodule

// File: rtl/fpa_div_track.sv
module fpa_div_track #(
  parameter int SP_LAT = 15,
  parameter int DP_LAT = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  logic dbl,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(DP_LAT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    if (issue)
      cnt_d = dbl ? CW'(DP_LAT - 1) : CW'(SP_LAT - 1);
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
    else
      cnt_d = '0;
    done_d = (cnt_q == CW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign busy = cnt_q != '0;
  assign done = done_q;

  p_busy_after_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> busy);
  p_no_issue_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !issue);
  p_done_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/fpa_issue.sv
module fpa_issue
  import fpa_pkg::*;
#(
  parameter int PIPE_LAT   = 4,
  parameter int BR_LAT     = 1,
  parameter int DIV_SP_LAT = 15,
  parameter int DIV_DP_LAT = 22
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       s0_vld,
  input  logic [2:0] s0_cls,
  input  logic       s0_dbl,
  input  logic       s1_vld,
  input  logic [2:0] s1_cls,
  input  logic       s1_dbl,
  output logic       s0_gnt,
  output logic       s0_pipe,
  output logic       s1_gnt,
  output logic       s1_pipe,
  output logic       div_busy,
  output logic       a_res_vld,
  output logic       m_res_vld,
  output logic       div_res_vld
);
  localparam int NSLOT = 2;

  logic [NSLOT-1:0]       gnt, pipe, dblv;
  logic [CLS_W-1:0]       cls [NSLOT];
  logic [NSLOT-1:0]       a_long, a_short, m_long;
  logic                   div_go, div_dbl;
  logic [1:0]             res;

  fpa_arb u_arb (
    .s0_vld  (s0_vld),
    .s0_cls  (s0_cls),
    .s1_vld  (s1_vld),
    .s1_cls  (s1_cls),
    .div_busy(div_busy),
    .gnt0    (gnt[0]),
    .pipe0   (pipe[0]),
    .gnt1    (gnt[1]),
    .pipe1   (pipe[1])
  );

  assign cls[0]  = s0_cls;
  assign cls[1]  = s1_cls;
  assign dblv[0] = s0_dbl;
  assign dblv[1] = s1_dbl;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign a_long[i]  = gnt[i] && (pipe[i] == P_A) &&
                        ((cls[i] == C_ADD) || (cls[i] == C_CMOV) || (cls[i] == C_CPYS));
    assign a_short[i] = gnt[i] && (cls[i] == C_BR);
    assign m_long[i]  = gnt[i] && (pipe[i] == P_M);
  end

  always_comb begin
    div_go  = 1'b0;
    div_dbl = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      if (gnt[i] && (cls[i] == C_DIV)) begin
        div_go  = 1'b1;
        div_dbl = dblv[i];
      end
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_pipe
    fpa_lat_pipe #(
      .LONG_LAT (PIPE_LAT),
      .SHORT_LAT(BR_LAT)
    ) u_lat (
      .clk      (clk),
      .rst_n    (rst_n),
      .inj_long (p == 0 ? (|a_long)  : (|m_long)),
      .inj_short(p == 0 ? (|a_short) : 1'b0),
      .res_vld  (res[p])
    );
  end

  fpa_div_track #(
    .SP_LAT(DIV_SP_LAT),
    .DP_LAT(DIV_DP_LAT)
  ) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .issue(div_go),
    .dbl  (div_dbl),
    .busy (div_busy),
    .done (div_res_vld)
  );

  assign s0_gnt    = gnt[0];
  assign s0_pipe   = pipe[0];
  assign s1_gnt    = gnt[1];
  assign s1_pipe   = pipe[1];
  assign a_res_vld = res[0];
  assign m_res_vld = res[1];

  p_in_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_gnt && s0_vld) |-> s0_gnt);
  p_pipe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_gnt && s1_gnt) |-> (s0_pipe != s1_pipe));
  p_branch_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_gnt && (s0_cls == C_BR)) |=> a_res_vld);
  p_bad_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_cls > C_DIV) |-> !s0_gnt);
endmodule

// File: tb/sim_fpa_issue.sv
module sim_fpa_issue;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s0_vld = 0, s0_dbl = 0, s1_vld = 0, s1_dbl = 0;
  logic [2:0] s0_cls = 0, s1_cls = 0;
  logic s0_gnt, s0_pipe, s1_gnt, s1_pipe, div_busy;
  logic a_res_vld, m_res_vld, div_res_vld;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fpa_issue u0 (.*);

  // {s0_vld, s0_cls, s0_dbl, s1_vld, s1_cls, s1_dbl, gnt0, pipe0, gnt1, pipe1}
  localparam int NV = 14;
  localparam logic [13:0] VEC [NV] = '{
    {1'b1,3'd0,1'b0, 1'b1,3'd3,1'b0, 4'b1011},
    {1'b1,3'd3,1'b0, 1'b1,3'd0,1'b0, 4'b1110},
    {1'b1,3'd0,1'b0, 1'b1,3'd0,1'b0, 4'b1000},
    {1'b1,3'd4,1'b0, 1'b1,3'd0,1'b0, 4'b1110},
    {1'b1,3'd4,1'b0, 1'b1,3'd3,1'b0, 4'b1011},
    {1'b1,3'd0,1'b0, 1'b1,3'd4,1'b0, 4'b1011},
    {1'b1,3'd3,1'b0, 1'b1,3'd4,1'b0, 4'b1110},
    {1'b1,3'd4,1'b0, 1'b1,3'd4,1'b0, 4'b1011},
    {1'b0,3'd0,1'b0, 1'b1,3'd2,1'b0, 4'b0010},
    {1'b1,3'd6,1'b0, 1'b1,3'd0,1'b0, 4'b0000},
    {1'b1,3'd3,1'b0, 1'b1,3'd3,1'b0, 4'b1100},
    {1'b1,3'd2,1'b0, 1'b1,3'd1,1'b0, 4'b1000},
    {1'b1,3'd1,1'b0, 1'b1,3'd7,1'b0, 4'b1000},
    {1'b0,3'd0,1'b0, 1'b1,3'd4,1'b0, 4'b0010}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic clear_in();
    s0_vld = 0; s1_vld = 0; s0_cls = 0; s1_cls = 0; s0_dbl = 0; s1_dbl = 0;
  endtask

  // issue one op in slot 0 and watch a result line for lat+1 cycles
  task automatic lat_probe(input string req, input logic [2:0] c, input int which,
                           input int lat, input logic exp_pipe);
    @(negedge clk);
    s0_vld = 1; s0_cls = c;
    #1;
    chk(req, {6'd0, s0_gnt, s0_pipe}, {6'd0, 1'b1, exp_pipe});
    for (int k = 1; k <= lat + 1; k++) begin
      @(negedge clk);
      if (k == 1) clear_in();
      chk(req, {7'd0, (which == 0) ? a_res_vld : m_res_vld}, {7'd0, k == lat});
    end
  endtask

  initial begin
    #(20 * 5000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    // R1 reset state
    chk("R1", {4'd0, div_busy, a_res_vld, m_res_vld, div_res_vld}, 8'd0);

    // grant table: R5 R6 R7 R11
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {s0_vld, s0_cls, s0_dbl, s1_vld, s1_cls, s1_dbl} = VEC[i][13:4];
      #1;
      chk("R5/R6/R7/R11 grant", {4'd0, s0_gnt, s0_pipe, s1_gnt, s1_pipe}, {4'd0, VEC[i][3:0]});
    end
    @(negedge clk);
    clear_in();
    idle(6);

    lat_probe("R2 add", 3'd0, 0, 4, 1'b0);
    lat_probe("R2 cmov", 3'd1, 0, 4, 1'b0);
    lat_probe("R3 branch", 3'd2, 0, 1, 1'b0);
    lat_probe("R4 mul", 3'd3, 1, 4, 1'b1);
    lat_probe("R5 cpys", 3'd4, 0, 4, 1'b0);

    // R5: copy-sign moved to M, result on M at 4
    @(negedge clk);
    s0_vld = 1; s0_cls = 3'd4; s1_vld = 1; s1_cls = 3'd0;
    #1;
    chk("R5 moved", {6'd0, s0_pipe, s1_pipe}, 8'b10);
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (k == 1) clear_in();
      chk("R5 both pipes", {6'd0, a_res_vld, m_res_vld}, (k == 4) ? 8'b11 : 8'b00);
    end

    // R11: code 6 yields nothing
    @(negedge clk);
    s0_vld = 1; s0_cls = 3'd6;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (k == 1) clear_in();
      chk("R11 no result", {5'd0, a_res_vld, m_res_vld, div_res_vld}, 8'd0);
    end

    // R8 single divide, R10 blocking
    @(negedge clk);
    s0_vld = 1; s0_cls = 3'd5; s0_dbl = 0;
    #1;
    chk("R8 div grant", {6'd0, s0_gnt, s0_pipe}, 8'b10);
    for (int k = 1; k <= 15; k++) begin
      @(negedge clk);
      if (k == 1) clear_in();
      if (k < 15)
        chk("R8 busy", {6'd0, div_busy, div_res_vld}, 8'b10);
      if (k == 5) begin
        s1_vld = 1; s1_cls = 3'd5;
        #1;
        chk("R10 blocked", {7'd0, s1_gnt}, 8'd0);
        clear_in();
      end
    end
    chk("R8 done", {6'd0, div_busy, div_res_vld}, 8'b01);
    // R10: new double divide accepted in the done cycle, R9 latency
    s0_vld = 1; s0_cls = 3'd5; s0_dbl = 1;
    #1;
    chk("R10 reissue", {7'd0, s0_gnt}, 8'd1);
    for (int k = 1; k <= 23; k++) begin
      @(negedge clk);
      if (k == 1) clear_in();
      chk("R9 dbl", {6'd0, div_busy, div_res_vld},
          (k < 22) ? 8'b10 : (k == 22) ? 8'b01 : 8'b00);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule